// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block links two data ports, A and B, with one storage element in each direction. Each storage element has three modes. It is transparent while its latch enable is high. It holds its value while the latch enable is low and its clock is steady. It captures its input on a rising clock edge while the latch enable is low. Each direction has its own output enable, and the two enables have opposite polarity: the A-to-B enable is active high and the B-to-A enable is active low. Data is never inverted.

The path is split into equal halves. Each half has its own set of latch enables, clocks and output enables, so the block can serve as one wide transceiver or as several narrow independent ones. A high-impedance output is represented by a per-half drive-enable signal next to the data output. A pad or inout wrapper at a higher level combines the two into a tri-state bus.

Top module: `bus_xcvr`

## Requirements
- R1: For half h, while `le_ab[h]` is high, `b_out[h*18 +: 18]` equals `a_in[h*18 +: 18]` combinationally. The value is not inverted.
- R2: While `le_ab[h]` is low and `cp_ab[h]` holds still, at either level, `b_out` for that half keeps its value and ignores `a_in`. When `le_ab[h]` falls, the output keeps the last value that passed through in transparent mode.
- R3: A rising edge of `cp_ab[h]` while `le_ab[h]` is low loads the current `a_in` half into the storage element. A rising edge while `le_ab[h]` is high has no effect beyond transparency.
- R4: `b_drv[h]` is 1 exactly when `oe_ab[h]` is 1 (active high). A 0 means the B side of that half is high-impedance.
- R5: `a_drv[h]` is 1 exactly when `oe_ba_n[h]` is 0 (active low). A 1 on `oe_ba_n[h]` means the A side of that half is high-impedance.
- R6: The B-to-A direction follows R1 to R3, using `le_ba[h]`, `cp_ba[h]`, `b_in` and `a_out`.
- R7: Half h owns bits [h*18 +: 18] of every data port and index h of every control port. Activity in one half or one direction leaves the outputs of every other half and direction unchanged.
- R8: While `rst_n` is low (asynchronous, active low), both storage elements of every half read zero. After release they keep zero until a transparent window or a clock capture writes them.
- R9: The most recent write wins. A clock capture that is followed by a transparent window leaves the transparent value stored once the latch enable falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all storage |
| a_in | input | 36 | Data arriving from the A side |
| b_in | input | 36 | Data arriving from the B side |
| le_ab | input | 2 | A-to-B latch enable per half (1 = transparent) |
| cp_ab | input | 2 | A-to-B capture clock per half (rising edge) |
| oe_ab | input | 2 | A-to-B output enable per half, active high |
| le_ba | input | 2 | B-to-A latch enable per half (1 = transparent) |
| cp_ba | input | 2 | B-to-A capture clock per half (rising edge) |
| oe_ba_n | input | 2 | B-to-A output enable per half, active low |
| a_out | output | 36 | Data driven toward the A side |
| a_drv | output | 2 | A-side drive enable per half (0 = high-impedance) |
| b_out | output | 36 | Data driven toward the B side |
| b_drv | output | 2 | B-side drive enable per half (0 = high-impedance) |

## Verification
The assertions check, at all times and for every half, that each output follows its input while the latch enable is high, that each drive enable follows the polarity of its own output enable, and that both outputs read zero while reset is held and the latch is closed. Several behaviours depend on the order of events, and only the bench scenarios can show them. These are holding against input changes, capture on a clock edge, a clock edge with no effect while the latch is transparent, retention at the latch-enable fall, the newest-write-wins order, and the isolation of one half or direction from the others.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned HALF_W_DEF = 18;
  localparam int unsigned HALVES_DEF = 2;

  function automatic int unsigned seg_lo(input int unsigned h, input int unsigned w);
    return h * w;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
// Merged level/edge storage: transparent while le is high; loads on a rising
// cp edge while le is low; otherwise holds whichever write came last.
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         rst_n,
  input  logic         le,
  input  logic         cp,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] lat_q;
  logic [W-1:0] ff_q;
  logic         ff_newer;

  // level path: follows d while le is high, keeps the last value on le fall
  always_latch begin
    if (!rst_n)  lat_q <= '0;
    else if (le) lat_q <= d;
  end

  // edge path: a rising le makes the level path the newest write again
  always_ff @(posedge cp or posedge le or negedge rst_n) begin
    if (!rst_n) begin
      ff_q     <= '0;
      ff_newer <= 1'b0;
    end else if (le) begin
      ff_newer <= 1'b0;
    end else begin
      ff_q     <= d;
      ff_newer <= 1'b1;
    end
  end

  always_comb begin
    if (le)            q = d;
    else if (ff_newer) q = ff_q;
    else               q = lat_q;
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int unsigned W = 18
) (
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         cp_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         cp_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b_out,
  output logic         b_drv
);
  xcvr_store #(.W(W)) u_ab (
    .rst_n(rst_n), .le(le_ab), .cp(cp_ab), .d(a_in), .q(b_out)
  );

  xcvr_store #(.W(W)) u_ba (
    .rst_n(rst_n), .le(le_ba), .cp(cp_ba), .d(b_in), .q(a_out)
  );

  assign b_drv = oe_ab;
  assign a_drv = ~oe_ba_n;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF,
  parameter int unsigned HALVES = HALVES_DEF
) (
  input  logic                     rst_n,
  input  logic [HALF_W*HALVES-1:0] a_in,
  input  logic [HALF_W*HALVES-1:0] b_in,
  input  logic [HALVES-1:0]        le_ab,
  input  logic [HALVES-1:0]        cp_ab,
  input  logic [HALVES-1:0]        oe_ab,
  input  logic [HALVES-1:0]        le_ba,
  input  logic [HALVES-1:0]        cp_ba,
  input  logic [HALVES-1:0]        oe_ba_n,
  output logic [HALF_W*HALVES-1:0] a_out,
  output logic [HALVES-1:0]        a_drv,
  output logic [HALF_W*HALVES-1:0] b_out,
  output logic [HALVES-1:0]        b_drv
);
  localparam int unsigned BUS_W = HALF_W * HALVES;

  logic [BUS_W-1:0] a_out_w;
  logic [BUS_W-1:0] b_out_w;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam int unsigned LO = seg_lo(h, HALF_W);
    xcvr_half #(.W(HALF_W)) u_half (
      .rst_n   (rst_n),
      .a_in    (a_in[LO +: HALF_W]),
      .b_in    (b_in[LO +: HALF_W]),
      .le_ab   (le_ab[h]),
      .cp_ab   (cp_ab[h]),
      .oe_ab   (oe_ab[h]),
      .le_ba   (le_ba[h]),
      .cp_ba   (cp_ba[h]),
      .oe_ba_n (oe_ba_n[h]),
      .a_out   (a_out_w[LO +: HALF_W]),
      .a_drv   (a_drv[h]),
      .b_out   (b_out_w[LO +: HALF_W]),
      .b_drv   (b_drv[h])
    );
  end

  assign a_out = a_out_w;
  assign b_out = b_out_w;
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int unsigned HALF_W = 18,
  parameter int unsigned HALVES = 2
) (
  input logic                     rst_n,
  input logic [HALF_W*HALVES-1:0] a_in,
  input logic [HALF_W*HALVES-1:0] b_in,
  input logic [HALVES-1:0]        le_ab,
  input logic [HALVES-1:0]        cp_ab,
  input logic [HALVES-1:0]        oe_ab,
  input logic [HALVES-1:0]        le_ba,
  input logic [HALVES-1:0]        cp_ba,
  input logic [HALVES-1:0]        oe_ba_n,
  input logic [HALF_W*HALVES-1:0] a_out,
  input logic [HALVES-1:0]        a_drv,
  input logic [HALF_W*HALVES-1:0] b_out,
  input logic [HALVES-1:0]        b_drv
);
  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    always_comb begin
      // R1: transparent A-to-B
      if (rst_n && le_ab[h])
        a_r1_transparent_ab: assert (b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W])
          else $error("R1 transparency broken in half %0d", h);
      // R6: transparent B-to-A
      if (rst_n && le_ba[h])
        a_r6_transparent_ba: assert (a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W])
          else $error("R6 transparency broken in half %0d", h);
      // R4: active-high B-side enable
      a_r4_b_drive: assert (b_drv[h] == oe_ab[h])
        else $error("R4 drive enable wrong in half %0d", h);
      // R5: active-low A-side enable
      a_r5_a_drive: assert (a_drv[h] == !oe_ba_n[h])
        else $error("R5 drive enable wrong in half %0d", h);
      // R8: cleared storage under reset
      if (!rst_n && !le_ab[h])
        a_r8_reset_ab: assert (b_out[h*HALF_W +: HALF_W] == '0)
          else $error("R8 A-to-B not cleared in half %0d", h);
      if (!rst_n && !le_ba[h])
        a_r8_reset_ba: assert (a_out[h*HALF_W +: HALF_W] == '0)
          else $error("R8 B-to-A not cleared in half %0d", h);
    end
  end
endmodule

bind bus_xcvr bus_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (.*);

// File: tb/sim_bus_xcvr.sv
`timescale 1ns/1ps
module sim_bus_xcvr;
  localparam int HW = 18;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [NH-1:0] le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n, a_drv, b_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_xcvr u0 (.*);

  function automatic logic [HW-1:0] pat(input int k);
    return HW'((k * 32'h9E37 + 32'h1357) ^ (k << 7));
  endfunction

  function automatic logic [HW-1:0] get_out(input int d, input int h);
    return (d == 0) ? b_out[h*HW +: HW] : a_out[h*HW +: HW];
  endfunction

  task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // d = 0: A-to-B, d = 1: B-to-A
  task automatic set_in(input int d, input int h, input logic [HW-1:0] v);
    if (d == 0) a_in[h*HW +: HW] = v; else b_in[h*HW +: HW] = v;
    #1;
  endtask
  task automatic set_le(input int d, input int h, input logic v);
    if (d == 0) le_ab[h] = v; else le_ba[h] = v;
    #1;
  endtask
  task automatic set_cp(input int d, input int h, input logic v);
    if (d == 0) cp_ab[h] = v; else cp_ba[h] = v;
    #1;
  endtask

  task automatic dir_seq(input int d, input int h, input int base);
    string rq;
    logic [HW-1:0] last;
    logic [HW-1:0] snap [2][NH];
    rq = (d == 0) ? "R1" : "R6";
    for (int dd = 0; dd < 2; dd++)
      for (int hh = 0; hh < NH; hh++) snap[dd][hh] = get_out(dd, hh);
    // transparent sweep
    set_le(d, h, 1'b1);
    for (int k = 0; k < 16; k++) begin
      set_in(d, h, pat(base + k));
      chk({rq, " transparent"}, get_out(d, h), pat(base + k));
    end
    last = pat(base + 15);
    // R2: retain on latch-enable fall, ignore input with clock low
    set_le(d, h, 1'b0);
    set_in(d, h, pat(base + 20));
    chk("R2 hold after le fall", get_out(d, h), last);
    // R3: capture on rising clock
    set_cp(d, h, 1'b1);
    chk("R3 capture on cp rise", get_out(d, h), pat(base + 20));
    // R2: clock held high, input ignored
    set_in(d, h, pat(base + 21));
    chk("R2 hold with cp high", get_out(d, h), pat(base + 20));
    set_cp(d, h, 1'b0);
    chk("R2 hold on cp fall", get_out(d, h), pat(base + 20));
    set_in(d, h, pat(base + 22));
    set_cp(d, h, 1'b1);
    chk("R3 second capture", get_out(d, h), pat(base + 22));
    set_cp(d, h, 1'b0);
    // R3: clock rise during transparency has no extra effect
    set_le(d, h, 1'b1);
    set_in(d, h, pat(base + 23));
    set_cp(d, h, 1'b1);
    set_in(d, h, pat(base + 24));
    chk("R3 cp rise while transparent", get_out(d, h), pat(base + 24));
    set_cp(d, h, 1'b0);
    set_le(d, h, 1'b0);
    set_in(d, h, pat(base + 25));
    chk("R3 le fall after cp keeps transparent value", get_out(d, h), pat(base + 24));
    // R9: capture, then transparent window, then le fall
    set_cp(d, h, 1'b1);
    chk("R9 capture before window", get_out(d, h), pat(base + 25));
    set_cp(d, h, 1'b0);
    set_in(d, h, pat(base + 26));
    set_le(d, h, 1'b1);
    set_le(d, h, 1'b0);
    set_in(d, h, pat(base + 27));
    chk("R9 newest write is transparent value", get_out(d, h), pat(base + 26));
    // R7: everything else untouched
    for (int dd = 0; dd < 2; dd++)
      for (int hh = 0; hh < NH; hh++)
        if (dd != d || hh != h) chk("R7 isolation", get_out(dd, hh), snap[dd][hh]);
  endtask

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    le_ab = '0; cp_ab = '0; le_ba = '0; cp_ba = '0;
    oe_ab = '0; oe_ba_n = '1;
    a_in = {BW{1'b1}}; b_in = {BW{1'b1}};
    repeat (3) @(posedge clk);
    #1;
    for (int h = 0; h < NH; h++) begin
      chk("R8 reset clears A-to-B", get_out(0, h), '0);
      chk("R8 reset clears B-to-A", get_out(1, h), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int h = 0; h < NH; h++) begin
      chk("R8 zero kept after release", get_out(0, h), '0);
      chk("R8 zero kept after release", get_out(1, h), '0);
    end

    // R4/R5: all enable combinations in every half
    for (int v = 0; v < 16; v++) begin
      @(posedge clk);
      oe_ab = v[1:0];
      oe_ba_n = v[3:2];
      #1;
      for (int h = 0; h < NH; h++) begin
        chk1("R4 b_drv active high", b_drv[h], v[h]);
        chk1("R5 a_drv active low", a_drv[h], !v[2 + h]);
      end
    end

    for (int d = 0; d < 2; d++)
      for (int h = 0; h < NH; h++) begin
        @(posedge clk);
        dir_seq(d, h, 40 * (2 * d + h) + 3);
      end

    // R8: reset in mid-run clears stored values
    @(posedge clk);
    for (int h = 0; h < NH; h++) begin
      chk1("R8 stored value nonzero before reset", (get_out(0, h) != '0), 1'b1);
    end
    rst_n = 1'b0;
    #1;
    for (int h = 0; h < NH; h++) begin
      chk("R8 mid-run reset A-to-B", get_out(0, h), '0);
      chk("R8 mid-run reset B-to-A", get_out(1, h), '0);
    end
    rst_n = 1'b1;
    a_in = '0 - 1; b_in = 36'h5A5A5A5A5;
    #1;
    chk("R8 hold zero after release", get_out(0, 1), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule